// File: doc/BRIEF.md
# Buffered Serial Transmitter with Clear-to-Send Gating

This block sends asynchronous serial frames on a single output line. Software-style register writes place a character into a one-entry holding buffer. When the shift stage is free, the character moves into the shift stage and goes out as a frame. A frame is a low start bit, 8 or 9 data bits sent least significant bit first, an optional even or odd parity bit, and one or two high stop bits. Because the buffer empties as soon as a frame starts, the next character can be queued during the current frame. Frames then follow each other with no idle time between them.

The bit time is 16 × (n + 1) clock cycles, where n is the value in the divider register. An optional clear-to-send input can hold back the start of any new frame while it is high. It never cuts into a frame already on the line. Two status outputs report the buffer state and the whole-transmitter state. A sticky interrupt request fires on a selectable event: either the buffer has emptied, or the transmission is complete. It stays set until it is acknowledged.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset, `txd` is 1, `buf_empty` is 1, `tx_empty` is 1 and `irq` is 0. The configuration register and the divider register both reset to 0.
- R2: Writing value n to address 1 (the divider, `wr_data[7:0]`) sets every bit on `txd` to last exactly 16 × (n + 1) clock cycles.
- R3: Each frame begins with one low bit. The data bits follow, least significant first. Configuration bit 1 selects 9 data bits (1) or 8 data bits (0).
- R4: Configuration bit 2 enables a parity bit, placed right after the last data bit. Configuration bit 3 selects odd parity (1) or even parity (0). Parity counts only the data bits that are actually sent.
- R5: Configuration bit 4 selects two stop bits (1) or one stop bit (0). Stop bits are high.
- R6: Writing address 0 while `buf_empty` is 1 fills the buffer, and `buf_empty` falls. The buffer moves to the shift stage when that stage is free, and `buf_empty` rises at that moment. A character queued during a frame starts on the cycle right after the last stop bit ends.
- R7: A write to address 0 while `buf_empty` is 0 is ignored. The queued character is the one sent, and no extra frame follows.
- R8: `tx_empty` is 1 exactly when no frame is on the line and the buffer is empty. `txd` is 1 whenever `tx_empty` is 1.
- R9: Configuration bit 6 selects the interrupt event. With 0, the event is the buffer moving into the shift stage. With 1, the event is the end of a frame's last stop bit with nothing left queued.
- R10: `irq` stays 1 until `irq_ack` is sampled high, and it returns to 0 on the next clock.
- R11: When configuration bit 5 is 1, no frame starts while `cts_i` is 1. Once `cts_i` is low, a queued frame starts on the next clock. A frame already running always completes.
- R12: When configuration bit 0 (transmit enable) is 0, no frame starts and the buffer keeps its character. Clearing it during a frame lets that frame finish.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, also the bit-rate count source |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | 0 data buffer, 1 divider, 2 configuration |
| wr_data | input | 9 | Write data |
| irq_ack | input | 1 | Clears the interrupt request |
| cts_i | input | 1 | Clear-to-send, high holds off new frames |
| txd | output | 1 | Serial output, idles high |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_empty | output | 1 | Nothing queued and nothing on the line |
| irq | output | 1 | Sticky interrupt request |

## Verification
Most internal faults in this block show up on `txd` within one frame. A wrong bit count or a wrong parity state changes the sampled bit pattern in the stop or parity position. A wrong divider count moves the first edge after the start bit by a whole number of cycles. A buffer handover state that is off by one shows up in two ways: as a gap or an overlap where back-to-back frames meet, or as `buf_empty` flipping on the wrong cycle. Gating faults show up as a start bit appearing while clear-to-send or transmit enable should hold the line high. A wrongly chosen interrupt event shows up on `irq` either at the first cycle of a frame or at the first cycle after it ends.

// File: rtl/uart_tx_pkg.sv
// Shared types and register addresses for the buffered serial transmitter.
// Assumes: the configuration word fits in the low 7 bits of a write.
package uart_tx_pkg;

    // Configuration register, bit 0 at the bottom of the struct.
    typedef struct packed {
        logic irq_on_done;  // bit 6: interrupt on transmission complete
        logic cts_en;       // bit 5: clear-to-send gating enabled
        logic stop2;        // bit 4: two stop bits
        logic par_odd;      // bit 3: odd parity
        logic par_en;       // bit 2: parity bit present
        logic len9;         // bit 1: nine data bits
        logic tx_en;        // bit 0: transmit enable
    } tx_cfg_t;

    localparam logic [1:0] ADDR_DATA = 2'd0;
    localparam logic [1:0] ADDR_DIV  = 2'd1;
    localparam logic [1:0] ADDR_CFG  = 2'd2;

endpackage

// File: rtl/uart_tx_baud.sv
// Bit-period counter: pulses tick once every OVS*(div+1) cycles while run is high.
// Assumes: OVS is a power of two; the counter is held at zero whenever run is low,
// so a frame that starts from idle gets a full first bit.
module uart_tx_baud #(
    parameter int DIV_W = 8,
    parameter int OVS   = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int OVS_W = $clog2(OVS);
    localparam int CNT_W = DIV_W + OVS_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = {div, {OVS_W{1'b1}}};
    assign tick = run && (cnt == last);

    // Count cycles inside the current bit; restart at each bit boundary or when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_frame.sv
// Combinational frame builder: turns one character and the format bits into a
// line-order bit vector (bit 0 goes out first) and the number of bits to send.
// Assumes: unused upper positions stay 1 so they read as idle/stop level.
module uart_tx_frame #(
    parameter int DATA_W = 9,
    localparam int FRAME_W = DATA_W + 4,
    localparam int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  logic               len9,
    input  logic               par_en,
    input  logic               par_odd,
    input  logic               stop2,
    output logic [FRAME_W-1:0] frame,
    output logic [LEN_W-1:0]   nbits
);
    // Place start, data and parity bits; stop bits come from the all-ones fill.
    always_comb begin
        logic pty;
        pty   = 1'b0;
        frame = '1;
        frame[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < DATA_W - 1 || len9) begin
                frame[i+1] = data[i];
                pty        = pty ^ data[i];
            end
        end
        if (par_en) begin
            if (len9) frame[DATA_W+1] = pty ^ par_odd;
            else      frame[DATA_W]   = pty ^ par_odd;
        end
        nbits = LEN_W'(DATA_W + 1) + LEN_W'(len9) + LEN_W'(par_en) + LEN_W'(stop2);
    end
endmodule

// File: rtl/uart_tx_shift.sv
// Shift stage: holds one frame and moves it out one bit per tick, LSB first.
// Assumes: load is only raised when the stage is idle or on its final tick.
module uart_tx_shift #(
    parameter int FRAME_W = 13,
    localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame_in,
    input  logic [LEN_W-1:0]   nbits_in,
    input  logic               tick,
    output logic               busy,
    output logic               frame_end,
    output logic               txd
);
    logic [FRAME_W-1:0] sh;
    logic [LEN_W-1:0]   left;

    assign frame_end = busy && tick && (left == LEN_W'(1));
    assign txd       = busy ? sh[0] : 1'b1;

    // Load a new frame or advance the current one at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            sh   <= '1;
            left <= '0;
        end else if (load) begin
            busy <= 1'b1;
            sh   <= frame_in;
            left <= nbits_in;
        end else if (tick) begin
            if (left == LEN_W'(1)) busy <= 1'b0;
            sh   <= {1'b1, sh[FRAME_W-1:1]};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/uart_tx_cts.sv
// Buffered serial transmitter top: register write port, one-entry holding
// buffer, clear-to-send gated handover, status flags and sticky interrupt.
// Assumes: DIV_W <= DATA_W and DATA_W >= 7 so one write word carries any register.
module uart_tx_cts #(
    parameter int DATA_W = 9,
    parameter int DIV_W  = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              irq_ack,
    input  logic              cts_i,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_empty,
    output logic              irq
);
    import uart_tx_pkg::*;

    localparam int FRAME_W = DATA_W + 4;
    localparam int LEN_W   = $clog2(FRAME_W + 1);
    localparam int CFG_W   = $bits(tx_cfg_t);

    tx_cfg_t            cfg;
    logic [DIV_W-1:0]   div_q;
    logic [DATA_W-1:0]  buf_data;
    logic               buf_full;
    logic               cfg_tx_en;
    logic               cfg_cts_en;
    logic               sh_busy;
    logic               sh_end;
    logic               bit_tick;
    logic               load;
    logic               wr_buf;
    logic               irq_evt;
    logic [FRAME_W-1:0] frame;
    logic [LEN_W-1:0]   nbits;

    assign cfg_tx_en  = cfg.tx_en;
    assign cfg_cts_en = cfg.cts_en;

    // R6 R11 R12: hand over only when the shifter is free, enabled and not held off.
    assign load   = buf_full && cfg_tx_en && !(cfg_cts_en && cts_i) && (!sh_busy || sh_end);
    // R7: buffer writes are taken only while the buffer is empty.
    assign wr_buf = wr_en && (wr_addr == ADDR_DATA) && !buf_full;
    // R9: pick the interrupt event.
    assign irq_evt = cfg.irq_on_done ? (sh_end && !buf_full) : load;

    assign buf_empty = !buf_full;
    assign tx_empty  = !sh_busy && !buf_full;  // R8

    // Configuration and divider registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg   <= '0;
            div_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CFG) cfg   <= tx_cfg_t'(wr_data[CFG_W-1:0]);
            if (wr_addr == ADDR_DIV) div_q <= wr_data[DIV_W-1:0];
        end
    end

    // Holding buffer: fill on accepted write, drain on handover.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_full <= 1'b0;
            buf_data <= '0;
        end else if (load) begin
            buf_full <= 1'b0;
        end else if (wr_buf) begin
            buf_full <= 1'b1;
            buf_data <= wr_data;
        end
    end

    // R10: sticky interrupt request, set wins over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)       irq <= 1'b0;
        else if (irq_evt) irq <= 1'b1;
        else if (irq_ack) irq <= 1'b0;
    end

    uart_tx_baud #(.DIV_W(DIV_W), .OVS(OVS)) u_baud (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (sh_busy),
        .div  (div_q),
        .tick (bit_tick)
    );

    uart_tx_frame #(.DATA_W(DATA_W)) u_frame (
        .data   (buf_data),
        .len9   (cfg.len9),
        .par_en (cfg.par_en),
        .par_odd(cfg.par_odd),
        .stop2  (cfg.stop2),
        .frame  (frame),
        .nbits  (nbits)
    );

    uart_tx_shift #(.FRAME_W(FRAME_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .frame_in (frame),
        .nbits_in (nbits),
        .tick     (bit_tick),
        .busy     (sh_busy),
        .frame_end(sh_end),
        .txd      (txd)
    );
endmodule

// File: rtl/uart_tx_cts_chk.sv
// Property checker for the buffered transmitter, attached by bind.
// Assumes: signals are sampled on the rising edge; reset is synchronous active-low.
module uart_tx_cts_chk (
    input logic clk,
    input logic rst_n,
    input logic txd,
    input logic buf_empty,
    input logic tx_empty,
    input logic irq,
    input logic irq_ack,
    input logic cts_i,
    input logic cts_en,
    input logic tx_en,
    input logic busy
);
    AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> txd);  // R8
    AST_EMPTY_NEEDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> buf_empty);  // R8
    AST_HANDOVER_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(buf_empty) |-> !txd);  // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);  // R10
    AST_CTS_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (cts_en && cts_i && !busy && !buf_empty) |=> !buf_empty);  // R11
    AST_DISABLED_HOLDS_BUF: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !buf_empty) |=> !buf_empty);  // R12
endmodule

bind uart_tx_cts uart_tx_cts_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .txd      (txd),
    .buf_empty(buf_empty),
    .tx_empty (tx_empty),
    .irq      (irq),
    .irq_ack  (irq_ack),
    .cts_i    (cts_i),
    .cts_en   (cfg_cts_en),
    .tx_en    (cfg_tx_en),
    .busy     (sh_busy)
);

// File: tb/uart_tx_cts_tb.sv
`timescale 1ns/1ps
module uart_tx_cts_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [8:0] wr_data = 9'd0;
    logic       irq_ack = 1'b0;
    logic       cts_i = 1'b0;
    logic       txd, buf_empty, tx_empty, irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    uart_tx_cts u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_ack(irq_ack), .cts_i(cts_i),
        .txd(txd), .buf_empty(buf_empty), .tx_empty(tx_empty), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = 9'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (txd !== 1'b0 && n < 20000);
        if (n >= 20000) chk("R3 start bit seen", 0, 1);
    endtask

    // Sample a frame at bit centres; pre = negedges already past the start (-1: wait for it).
    task automatic get_frame(input int nb, input int p, input int pre, output int f);
        int k = pre;
        if (k < 0) begin wait_start(); k = 0; end
        f = 'h1FFF;
        repeat (p/2 - k) @(negedge clk);
        f[0] = txd;
        for (int i = 1; i < nb; i++) begin
            repeat (p) @(negedge clk);
            f[i] = txd;
        end
    endtask

    function automatic int dlen(input int cfgw);
        return cfgw[1] ? 9 : 8;
    endfunction

    function automatic int frame_bits(input int cfgw);
        return 1 + dlen(cfgw) + cfgw[2] + 1 + cfgw[4];
    endfunction

    // Expected line pattern, bit 0 first, computed from R3/R4/R5.
    function automatic int exp_frame(input int d, input int cfgw);
        int dl = dlen(cfgw);
        int val = d & ((1 << dl) - 1);
        int e = 'h1FFF & ~((1 << (dl + 1)) - 1);
        e = e | (val << 1);
        if (cfgw[2]) begin
            int pb = ($countones(val) % 2) ^ cfgw[3];
            if (pb == 0) e = e & ~(1 << (dl + 1));
        end
        return e;
    endfunction

    task automatic cmp_frame(input string req, input int f, input int d, input int cfgw);
        int m = (1 << frame_bits(cfgw)) - 1;
        chk(req, f & m, exp_frame(d, cfgw) & m);
    endtask

    task automatic count_lows(input int cycles, output int lows);
        lows = 0;
        repeat (cycles) begin
            @(negedge clk);
            if (txd == 1'b0) lows++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f, lows, cfgw, nb, p;
        int vals[6] = '{'h000, 'h1FF, 'h0A5, 'h15A, 'h100, 'h001};
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 txd", txd, 1);
        chk("R1 buf_empty", buf_empty, 1);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 irq", irq, 0);

        // Format sweep, divider 0 (16 cycles per bit): R3 R4 R5 R8.
        p = 16;
        for (int c = 0; c < 16; c++) begin
            cfgw = 1 | (c[0] << 1) | (c[1] << 2) | (c[2] << 3) | (c[3] << 4);
            nb = frame_bits(cfgw);
            wr(2'd2, cfgw);
            foreach (vals[v]) begin
                wr(2'd0, vals[v]);
                get_frame(nb, p, -1, f);
                if (cfgw[2]) cmp_frame("R4 parity frame", f, vals[v], cfgw);
                else if (cfgw[4]) cmp_frame("R5 two-stop frame", f, vals[v], cfgw);
                else cmp_frame("R3 data frame", f, vals[v], cfgw);
                repeat (p/2 - 1) @(negedge clk);
                chk("R8 busy on last cycle", tx_empty, 0);
                chk("R5 stop level", txd, 1);
                @(negedge clk);
                chk("R8 empty after frame", tx_empty, 1);
            end
        end

        // Bit period for divider 0..3: R2.
        wr(2'd2, 1);
        for (int n = 0; n < 4; n++) begin
            p = 16 * (n + 1);
            wr(2'd1, n);
            wr(2'd0, 'h01);
            wait_start();
            repeat (p - 1) @(negedge clk);
            chk("R2 start bit last cycle", txd, 0);
            @(negedge clk);
            chk("R2 first data bit on time", txd, 1);
            repeat (10 * p) @(negedge clk);
        end
        wr(2'd1, 0);
        p = 16;

        // Back-to-back and ignored write: R6 R7.
        cfgw = 1; nb = 10;
        wr(2'd0, 'h3C);
        wait_start();
        chk("R6 buffer empties at start", buf_empty, 1);
        wr(2'd0, 'hC3);
        chk("R6 buffer holds queued", buf_empty, 0);
        wr(2'd0, 'h55);
        get_frame(nb, p, 4, f);
        cmp_frame("R6 first frame", f, 'h3C, cfgw);
        repeat (p/2) @(negedge clk);
        chk("R6 no gap between frames", txd, 0);
        chk("R6 buffer handed over", buf_empty, 1);
        get_frame(nb, p, 0, f);
        cmp_frame("R7 queued char kept", f, 'hC3, cfgw);
        repeat (p/2) @(negedge clk);
        chk("R7 idle after two frames", tx_empty, 1);
        count_lows(3 * p, lows);
        chk("R7 no third frame", lows, 0);

        // Interrupt on buffer empty: R9 R10.
        ack();
        chk("R10 ack clears", irq, 0);
        wr(2'd0, 'h81);
        @(negedge clk);
        chk("R9 irq on handover", irq, 1);
        repeat (50) @(negedge clk);
        chk("R10 irq held", irq, 1);
        ack();
        chk("R10 irq cleared by ack", irq, 0);
        repeat (12 * p) @(negedge clk);
        chk("R9 no second irq", irq, 0);

        // Interrupt on completion: R9 R8.
        wr(2'd2, 1 | (1 << 6));
        wr(2'd0, 'h42);
        wait_start();
        repeat (5 * p) @(negedge clk);
        chk("R9 no irq mid frame", irq, 0);
        repeat (nb * p - 1 - 5 * p) @(negedge clk);
        chk("R9 no irq before stop ends", irq, 0);
        @(negedge clk);
        chk("R9 irq at completion", irq, 1);
        chk("R8 empty at completion", tx_empty, 1);
        ack();

        // Clear-to-send gating: R11.
        wr(2'd2, 1 | (1 << 5));
        @(negedge clk); cts_i = 1'b1;
        wr(2'd0, 'h99);
        count_lows(5 * p, lows);
        chk("R11 held while cts high", lows, 0);
        chk("R11 buffer still full", buf_empty, 0);
        cts_i = 1'b0;
        @(negedge clk);
        chk("R11 starts at once", txd, 0);
        cts_i = 1'b1;
        wr(2'd0, 'h66);
        get_frame(nb, p, 2, f);
        cmp_frame("R11 frame completes", f, 'h99, cfgw);
        repeat (p/2) @(negedge clk);
        count_lows(4 * p, lows);
        chk("R11 next frame held", lows, 0);
        chk("R11 queued kept", buf_empty, 0);
        cts_i = 1'b0;
        @(negedge clk);
        chk("R11 resume start", txd, 0);
        get_frame(nb, p, 0, f);
        cmp_frame("R11 resumed frame", f, 'h66, cfgw);
        repeat (p) @(negedge clk);

        // Transmit disable: R12.
        wr(2'd2, 1);
        wr(2'd0, 'h0F);
        wait_start();
        wr(2'd2, 0);
        wr(2'd0, 'hF0);
        get_frame(nb, p, 4, f);
        cmp_frame("R12 frame finishes", f, 'h0F, cfgw);
        repeat (p/2) @(negedge clk);
        count_lows(4 * p, lows);
        chk("R12 no new frame", lows, 0);
        chk("R12 buffer kept", buf_empty, 0);
        chk("R12 not empty", tx_empty, 0);
        wr(2'd2, 1);
        @(negedge clk);
        chk("R12 start on enable", txd, 0);
        get_frame(nb, p, 0, f);
        cmp_frame("R12 held char sent", f, 'hF0, cfgw);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule